// File: doc/BRIEF.md
# Pixel Frame Packer with Sequence Tag

This block sits at the front of a display-link transmitter and turns each accepted pixel into one 24-bit frame word for a downstream shifter. A pixel arrives as 24-bit RGB, eight bits per colour, together with vertical sync, horizontal sync and data-enable controls. It is qualified by a pixel-valid strobe. The packer keeps the six most significant bits of each colour and appends the three control bits. It then adds a free-running 2-bit sequence tag and an odd parity bit, and registers the result.

The sequence tag advances by one on every frame and repeats every four frames. A receiver that loses word alignment can find the incrementing pattern again without any line-coding overhead. Only the bypass colour path is built here. A dither-enable input is present for pin compatibility and has no effect on the output. A rising edge of vertical sync between successive pixels marks the start of a video frame and is brought out as a single-cycle pulse next to the frame it belongs to.

Top module: `pix_frame_packer`

## Requirements
- R1: With rgbIn holding red in [23:16], green in [15:8] and blue in [7:0], frameWord[23:18] carries red[7:2], frameWord[17:12] carries green[7:2] and frameWord[11:6] carries blue[7:2]. The two low bits of each colour are dropped.
- R2: frameWord[5] carries vsIn, frameWord[4] carries hsIn and frameWord[3] carries deIn, each unmodified from the accepted pixel.
- R3: frameWord[0] is set so that the count of ones across all 24 bits of a valid frame is odd. The parity covers colour, controls and tag.
- R4: frameWord[2:1] holds the 2-bit sequence tag. It rises by one for each successive frame and wraps from 3 to 0.
- R5: While rstN is low at a clock edge, frameValid and sofPulse clear and the tag counter returns to 0. The first frame after reset carries tag 0.
- R6: frameValid is high in exactly the cycle after a clock edge that sampled pixelValid high. A cycle with pixelValid low produces no frame and leaves the tag unchanged.
- R7: sofPulse is high together with a frame when that pixel's vsIn is 1 and the previously accepted pixel's vsIn was 0. Before any pixel after reset, the previous value is taken as 0.
- R8: ditherEn has no effect on frameWord, frameValid or sofPulse.
- R9: While no frame is produced, frameWord keeps the last frame it held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Synchronous reset, active low |
| pixelValid | input | 1 | Accept the pixel presented this cycle |
| ditherEn | input | 1 | Dither request; bypass only, ignored |
| rgbIn | input | 24 | Red [23:16], green [15:8], blue [7:0] |
| vsIn | input | 1 | Vertical sync |
| hsIn | input | 1 | Horizontal sync |
| deIn | input | 1 | Data enable |
| frameValid | output | 1 | Frame word valid this cycle |
| frameWord | output | 24 | Packed frame, MSB first to the shifter |
| sofPulse | output | 1 | Start of video frame, aligned with frameValid |

## Verification
Random RGB values with random control bits and random idle gaps test colour truncation, parity and tag advance. The gaps separate a tag that counts pixels from one that counts clock cycles, and catch a word that changes while idle. Runs of more than four back-to-back pixels exercise the 3-to-0 wrap. A vsIn that rises during an idle gap tells whether the start-of-frame edge is taken between accepted pixels or between raw cycles. The same pixel sent with ditherEn high and then low, once all other state is equal, must give identical words.

// File: rtl/pfp_pkg.sv
package pfp_pkg;
  localparam int COLOR_IN_W  = 8;
  localparam int COLOR_OUT_W = 6;
  localparam int TAG_W       = 2;
  localparam int NUM_CH      = 3;

  // Strobes from control to datapath
  typedef struct packed {
    logic             load;
    logic [TAG_W-1:0] tag;
    logic             sof;
  } pfpStrobe_t;
endpackage

// File: rtl/pfp_control.sv
module pfp_control
  import pfp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pixelValid,
  input  logic       vsIn,
  output pfpStrobe_t ctl
);
  logic [TAG_W-1:0] seqCnt;
  logic             lastVs;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seqCnt <= '0;
      lastVs <= 1'b0;
    end else if (pixelValid) begin
      seqCnt <= seqCnt + 1'b1;
      lastVs <= vsIn;
    end
  end

  always_comb begin
    ctl.load = pixelValid;
    ctl.tag  = seqCnt;
    ctl.sof  = vsIn & ~lastVs;
  end

  AST_TAG_STEP: assert property (@(posedge clk) disable iff (!rstN)
    pixelValid |=> seqCnt == TAG_W'($past(seqCnt) + 1'b1)); // R4
  AST_TAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !pixelValid |=> $stable(seqCnt)); // R6
endmodule

// File: rtl/pfp_datapath.sv
module pfp_datapath
  import pfp_pkg::*;
#(
  parameter int IN_W  = COLOR_IN_W,
  parameter int OUT_W = COLOR_OUT_W,
  localparam int RGB_W   = NUM_CH * IN_W,
  localparam int COLOR_W = NUM_CH * OUT_W,
  localparam int FRAME_W = COLOR_W + 3 + TAG_W + 1
)(
  input  logic               clk,
  input  logic               rstN,
  input  pfpStrobe_t         ctl,
  input  logic [RGB_W-1:0]   rgbIn,
  input  logic               vsIn,
  input  logic               hsIn,
  input  logic               deIn,
  output logic               frameValid,
  output logic [FRAME_W-1:0] frameWord,
  output logic               sofPulse
);
  logic [COLOR_W-1:0]   colorBits;
  logic [FRAME_W-2:0]   body;
  logic                 parityBit;

  // Bypass path: keep the MSBs of each channel
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_trunc
    assign colorBits[ch*OUT_W +: OUT_W] = rgbIn[ch*IN_W + (IN_W-OUT_W) +: OUT_W];
  end

  assign body      = {colorBits, vsIn, hsIn, deIn, ctl.tag};
  assign parityBit = ~(^body);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameValid <= 1'b0;
      sofPulse   <= 1'b0;
      frameWord  <= '0;
    end else begin
      frameValid <= ctl.load;
      sofPulse   <= ctl.load & ctl.sof;
      if (ctl.load) frameWord <= {body, parityBit};
    end
  end

  AST_FRAME_FOLLOWS_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> frameValid); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> !frameValid && $stable(frameWord)); // R9
  AST_ODD_PARITY: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |-> (^frameWord) == 1'b1); // R3
  AST_TAG_CARRIED: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> frameWord[TAG_W:1] == $past(ctl.tag)); // R4
  AST_SOF_WITH_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    sofPulse |-> frameValid); // R7
endmodule

// File: rtl/pix_frame_packer.sv
module pix_frame_packer
  import pfp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pixelValid,
  input  logic        ditherEn,
  input  logic [23:0] rgbIn,
  input  logic        vsIn,
  input  logic        hsIn,
  input  logic        deIn,
  output logic        frameValid,
  output logic [23:0] frameWord,
  output logic        sofPulse
);
  pfpStrobe_t ctl;

  // Only the bypass colour path exists; the request is accepted and dropped.
  logic unusedDither;
  assign unusedDither = ditherEn;

  pfp_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .pixelValid (pixelValid),
    .vsIn       (vsIn),
    .ctl        (ctl)
  );

  pfp_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .rgbIn      (rgbIn),
    .vsIn       (vsIn),
    .hsIn       (hsIn),
    .deIn       (deIn),
    .frameValid (frameValid),
    .frameWord  (frameWord),
    .sofPulse   (sofPulse)
  );

  AST_RESET_FIRST_TAG: assert property (@(posedge clk)
    !rstN ##1 (rstN && pixelValid) |=> frameWord[2:1] == 2'd0); // R5
endmodule

// File: tb/sim_pix_frame_packer.sv
module sim_pix_frame_packer;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pixelValid = 1'b0;
  logic        ditherEn = 1'b0;
  logic [23:0] rgbIn = '0;
  logic        vsIn = 1'b0, hsIn = 1'b0, deIn = 1'b0;
  logic        frameValid, sofPulse;
  logic [23:0] frameWord;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // bench model state
  logic [1:0]  mTag = 2'd0;
  logic        mLastVs = 1'b0;
  logic [23:0] mWord = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pix_frame_packer u0 (
    .clk(clk), .rstN(rstN), .pixelValid(pixelValid), .ditherEn(ditherEn),
    .rgbIn(rgbIn), .vsIn(vsIn), .hsIn(hsIn), .deIn(deIn),
    .frameValid(frameValid), .frameWord(frameWord), .sofPulse(sofPulse)
  );

  function automatic logic [23:0] packWord(input logic [23:0] rgb, input logic vs,
                                           input logic hs, input logic de, input logic [1:0] tag);
    logic [22:0] b;
    b = {rgb[23:18], rgb[15:10], rgb[7:2], vs, hs, de, tag};
    return {b, ~(^b)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive at negedge, check just after the following posedge.
  task automatic step(input logic v, input logic [23:0] rgb, input logic vs,
                      input logic hs, input logic de, input logic dith);
    logic expSof;
    @(negedge clk);
    pixelValid = v; rgbIn = rgb; vsIn = vs; hsIn = hs; deIn = de; ditherEn = dith;
    @(posedge clk);
    #1;
    check("R6 frameValid", {31'b0, frameValid}, {31'b0, v});
    if (v) begin
      expSof  = vs & ~mLastVs;
      mWord   = packWord(rgb, vs, hs, de, mTag);
      mTag    = mTag + 2'd1;
      mLastVs = vs;
      check("R1 R2 R3 R4 frameWord", {8'b0, frameWord}, {8'b0, mWord});
      check("R7 sofPulse", {31'b0, sofPulse}, {31'b0, expSof});
    end else begin
      check("R9 frameWord hold", {8'b0, frameWord}, {8'b0, mWord});
      check("R7 sofPulse idle", {31'b0, sofPulse}, 32'd0);
    end
  endtask

  initial begin
    logic [23:0] wA;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check("R5 reset frameValid", {31'b0, frameValid}, 32'd0);
    check("R5 reset sofPulse", {31'b0, sofPulse}, 32'd0);
    @(negedge clk); rstN = 1'b1;

    // R5: first frame after reset carries tag 0; R1 directed all-ones in low bits
    step(1'b1, 24'h030303, 1'b0, 1'b1, 1'b1, 1'b0);
    check("R5 first tag", {30'b0, frameWord[2:1]}, 32'd0);
    check("R1 low bits dropped", {8'b0, frameWord[23:6]}, 32'd0);
    // R4 wrap: run six back-to-back frames
    for (int i = 0; i < 6; i++) step(1'b1, 24'hFCFCFC, 1'b0, 1'b0, 1'b1, 1'b0);
    // R7: VS rises during an idle gap, seen on next accepted pixel
    step(1'b0, 24'h0, 1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b1, 24'h123456, 1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b1, 24'h654321, 1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b1, 24'h111111, 1'b0, 1'b0, 1'b0, 1'b0);
    // R8: same pixel with and without dither at matching tag and VS history
    step(1'b1, 24'hA5C33C, 1'b0, 1'b1, 1'b0, 1'b1);
    wA = frameWord;
    for (int i = 0; i < 3; i++) step(1'b1, 24'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 24'hA5C33C, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R8 dither ignored", {8'b0, frameWord}, {8'b0, wA});

    // Random phase
    for (int i = 0; i < 2000; i++) begin
      step(($urandom % 4) != 0, 24'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom));
    end

    // R5: reset mid-stream, then first tag 0 again
    @(negedge clk); rstN = 1'b0; pixelValid = 1'b0;
    @(posedge clk); #1;
    check("R5 reset clears valid", {31'b0, frameValid}, 32'd0);
    @(negedge clk); rstN = 1'b1;
    mTag = 2'd0; mLastVs = 1'b0; mWord = '0;
    step(1'b1, 24'hFFFFFF, 1'b1, 1'b1, 1'b1, 1'b0);
    check("R5 tag after reset", {30'b0, frameWord[2:1]}, 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule